// File: doc/BRIEF.md
# Configurable Signal Interposer

The interposer sits on a bus inside base logic and lets an optional monitor layer watch, block, divert or replace the traffic on it. One instance covers a whole bus of parameterised width under a single mode. The data path from the base input to the two outputs is purely combinational. The mode and the substitute value are captured on a clock edge, so a change requested by the monitor takes hold cleanly on the next cycle.

The block has four behaviours:
- **Observe:** the bus passes through and a copy goes to the monitor.
- **Block:** the bus carries a fixed idle value.
- **Divert:** the value goes to the monitor and the bus carries the idle value.
- **Substitute:** the bus carries the monitor's inject value.

When the monitor layer reports itself absent, the block reduces to a plain wire and its monitor-side output stays at zero, whatever the mode bits say.

Top module: `sig_interposer`

## Requirements
- R1: With the layer present and the registered mode 00 (observe), baseOut equals baseIn and obsOut equals baseIn.
- R2: With the layer present and the registered mode 01 (block), baseOut equals IDLE_VAL (default all zeros) and obsOut is zero.
- R3: With the layer present and the registered mode 10 (divert), obsOut equals baseIn and baseOut equals IDLE_VAL.
- R4: With the layer present and the registered mode 11 (substitute), baseOut equals the injIn value captured at the most recent rising clock edge, and obsOut is zero.
- R5: With layerPresent low, baseOut equals baseIn in every mode, and it follows layerPresent without waiting for a clock edge.
- R6: With layerPresent low, obsOut is zero in every mode.
- R7: modeSel and injIn act only through registers loaded at a rising edge. A change between edges leaves the outputs as they were until the next rising edge.
- R8: While rstN is low, and after it rises until the first new mode is captured, the registered mode is 00 (observe) and the captured inject value is zero.
- R9: A change on baseIn reaches baseOut and obsOut within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode and inject registers |
| rstN | input | 1 | Active-low asynchronous reset |
| baseIn | input | W | Value arriving on the base-logic bus |
| baseOut | output | W | Value driven onward on the base-logic bus |
| obsOut | output | W | Copy of the bus presented to the monitor |
| injIn | input | W | Substitute value supplied by the monitor |
| modeSel | input | 2 | Requested mode: 00 observe, 01 block, 10 divert, 11 substitute |
| layerPresent | input | 1 | High when the monitor layer is present |

## Verification
The timing split between paths is the hardest thing to show from the ports. The bus path is combinational, while the mode and inject paths pass through a register. To separate them, the bench changes modeSel, injIn, baseIn and layerPresent between clock edges and samples both before and after the next rising edge. A combinational leak of the mode or inject value would show up before that edge. A registered bus path, or a registered layer fallback, would show up as a stale value.

// File: rtl/sig_interposer_pkg.sv
package sig_interposer_pkg;

  typedef enum logic [1:0] {
    MODE_OBSERVE = 2'b00,
    MODE_BLOCK   = 2'b01,
    MODE_DIVERT  = 2'b10,
    MODE_SUBST   = 2'b11
  } ipMode_e;

  typedef struct packed {
    logic passEn;  // bus carries baseIn
    logic obsEn;   // monitor sees baseIn
    logic injEn;   // bus carries captured inject value
  } ipStrobes_t;

endpackage

// File: rtl/sig_interposer_ctrl.sv
module sig_interposer_ctrl
  import sig_interposer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   modeSel,
  input  logic [W-1:0] injIn,
  input  logic         layerPresent,
  output ipStrobes_t   strobes,
  output logic [W-1:0] injData
);

  ipMode_e modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MODE_OBSERVE;
      injData <= '0;
    end else begin
      modeReg <= ipMode_e'(modeSel);
      injData <= injIn;
    end
  end

  // layer presence stays unregistered so the fallback is immediate
  always_comb begin
    strobes = '{passEn: 1'b1, obsEn: 1'b0, injEn: 1'b0};
    if (layerPresent) begin
      unique case (modeReg)
        MODE_OBSERVE: strobes = '{passEn: 1'b1, obsEn: 1'b1, injEn: 1'b0};
        MODE_BLOCK:   strobes = '{passEn: 1'b0, obsEn: 1'b0, injEn: 1'b0};
        MODE_DIVERT:  strobes = '{passEn: 1'b0, obsEn: 1'b1, injEn: 1'b0};
        MODE_SUBST:   strobes = '{passEn: 1'b0, obsEn: 1'b0, injEn: 1'b1};
        default:      strobes = '{passEn: 1'b1, obsEn: 1'b0, injEn: 1'b0};
      endcase
    end
  end

endmodule

// File: rtl/sig_interposer_dp.sv
module sig_interposer_dp
  import sig_interposer_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] IDLE_VAL = '0
) (
  input  logic [W-1:0] baseIn,
  input  logic [W-1:0] injData,
  input  ipStrobes_t   strobes,
  output logic [W-1:0] baseOut,
  output logic [W-1:0] obsOut
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      if (strobes.passEn)     baseOut[b] = baseIn[b];
      else if (strobes.injEn) baseOut[b] = injData[b];
      else                    baseOut[b] = IDLE_VAL[b];
      obsOut[b] = strobes.obsEn & baseIn[b];
    end
  end

endmodule

// File: rtl/sig_interposer.sv
module sig_interposer
  import sig_interposer_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] IDLE_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] baseIn,
  output logic [W-1:0] baseOut,
  output logic [W-1:0] obsOut,
  input  logic [W-1:0] injIn,
  input  logic [1:0]   modeSel,
  input  logic         layerPresent
);

  ipStrobes_t   strobes;
  logic [W-1:0] injData;

  sig_interposer_ctrl #(.W(W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeSel      (modeSel),
    .injIn        (injIn),
    .layerPresent (layerPresent),
    .strobes      (strobes),
    .injData      (injData)
  );

  sig_interposer_dp #(.W(W), .IDLE_VAL(IDLE_VAL)) u_dp (
    .baseIn  (baseIn),
    .injData (injData),
    .strobes (strobes),
    .baseOut (baseOut),
    .obsOut  (obsOut)
  );

endmodule

// File: rtl/sig_interposer_chk.sv
module sig_interposer_chk #(
  parameter int           W        = 8,
  parameter logic [W-1:0] IDLE_VAL = '0
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] baseIn,
  input logic [W-1:0] baseOut,
  input logic [W-1:0] obsOut,
  input logic [W-1:0] injIn,
  input logic [1:0]   modeSel,
  input logic         layerPresent
);

  // checker's own record of the port values seen at the previous edge (R8 reset values)
  logic [1:0]   seenMode;
  logic [W-1:0] seenInj;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenMode <= 2'b00;
      seenInj  <= '0;
    end else begin
      seenMode <= modeSel;
      seenInj  <= injIn;
    end
  end

  a_r1_observe: assert property (@(posedge clk) disable iff (!rstN)
    (layerPresent && seenMode == 2'b00) |-> (baseOut == baseIn && obsOut == baseIn));

  a_r2_block: assert property (@(posedge clk) disable iff (!rstN)
    (layerPresent && seenMode == 2'b01) |-> (baseOut == IDLE_VAL && obsOut == '0));

  a_r3_divert: assert property (@(posedge clk) disable iff (!rstN)
    (layerPresent && seenMode == 2'b10) |-> (baseOut == IDLE_VAL && obsOut == baseIn));

  a_r4_subst: assert property (@(posedge clk) disable iff (!rstN)
    (layerPresent && seenMode == 2'b11) |-> (baseOut == seenInj && obsOut == '0));

  a_r5_absent_pass: assert property (@(posedge clk) disable iff (!rstN)
    !layerPresent |-> (baseOut == baseIn));

  a_r6_absent_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !layerPresent |-> (obsOut == '0));

endmodule

bind sig_interposer sig_interposer_chk #(.W(W), .IDLE_VAL(IDLE_VAL)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .baseIn       (baseIn),
  .baseOut      (baseOut),
  .obsOut       (obsOut),
  .injIn        (injIn),
  .modeSel      (modeSel),
  .layerPresent (layerPresent)
);

// File: tb/sig_interposer_tb.sv
module sig_interposer_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] baseIn = '0;
  logic [W-1:0] injIn = '0;
  logic [1:0]   modeSel = 2'b00;
  logic         layerPresent = 1'b0;
  logic [W-1:0] baseOut, obsOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sig_interposer #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .baseIn(baseIn), .baseOut(baseOut), .obsOut(obsOut),
    .injIn(injIn), .modeSel(modeSel), .layerPresent(layerPresent)
  );

  // {layer, mode, inject, baseIn, expected baseOut, expected obsOut, requirement}
  typedef struct packed {
    logic        layer;
    logic [1:0]  mode;
    logic [7:0]  inj;
    logic [7:0]  din;
    logic [7:0]  expOut;
    logic [7:0]  expObs;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b00, 8'h00, 8'hA5, 8'hA5, 8'hA5, 8'd1},  // R1
    '{1'b1, 2'b01, 8'h11, 8'h3C, 8'h00, 8'h00, 8'd2},  // R2
    '{1'b1, 2'b10, 8'h22, 8'h5A, 8'h00, 8'h5A, 8'd3},  // R3
    '{1'b1, 2'b11, 8'hC3, 8'h77, 8'hC3, 8'h00, 8'd4},  // R4
    '{1'b0, 2'b11, 8'hC3, 8'h77, 8'h77, 8'h00, 8'd5},  // R5
    '{1'b0, 2'b10, 8'h11, 8'h81, 8'h81, 8'h00, 8'd6},  // R6
    '{1'b0, 2'b01, 8'h11, 8'hFF, 8'hFF, 8'h00, 8'd5},  // R5
    '{1'b1, 2'b11, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'd4},  // R4
    '{1'b1, 2'b10, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'd3},  // R3
    '{1'b0, 2'b00, 8'h00, 8'h42, 8'h42, 8'h00, 8'd6}   // R6
  };

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // R8: in reset, a requested mode of 11 is not yet in force, so observe applies
    layerPresent = 1'b1;
    modeSel = 2'b11;
    injIn   = 8'hEE;
    baseIn  = 8'h96;
    @(posedge clk); @(posedge clk);
    #1;
    check("R8 reset baseOut", baseOut, 8'h96);
    check("R8 reset obsOut", obsOut, 8'h96);
    @(negedge clk);
    modeSel = 2'b00;
    injIn   = 8'h00;
    rstN = 1'b1;
    @(negedge clk);

    // table walk: drive at negedge, sample 2 ns after the capturing edge
    for (int i = 0; i < NV; i++) begin
      layerPresent = VECS[i].layer;
      modeSel      = VECS[i].mode;
      injIn        = VECS[i].inj;
      baseIn       = VECS[i].din;
      @(posedge clk);
      #2;
      check($sformatf("R%0d vec%0d baseOut", VECS[i].req, i), baseOut, VECS[i].expOut);
      check($sformatf("R%0d vec%0d obsOut", VECS[i].req, i), obsOut, VECS[i].expObs);
      @(negedge clk);
    end

    // R7: mode change between edges has no effect until the next edge
    layerPresent = 1'b1;
    modeSel = 2'b00;
    baseIn  = 8'h5C;
    @(posedge clk); @(negedge clk);
    modeSel = 2'b01;
    #1;
    check("R7 mode held baseOut", baseOut, 8'h5C);
    check("R7 mode held obsOut", obsOut, 8'h5C);
    @(posedge clk); #2;
    check("R7 mode applied baseOut", baseOut, 8'h00);

    // R7: inject change between edges is held back
    @(negedge clk);
    modeSel = 2'b11;
    injIn   = 8'h3A;
    @(posedge clk); #2;
    check("R4 subst baseOut", baseOut, 8'h3A);
    injIn = 8'hB1;
    #1;
    check("R7 inject held", baseOut, 8'h3A);
    @(posedge clk); #2;
    check("R7 inject applied", baseOut, 8'hB1);

    // R9: baseIn change mid-cycle reaches outputs without an edge
    @(negedge clk);
    modeSel = 2'b10;
    baseIn  = 8'h10;
    @(posedge clk); #2;
    baseIn = 8'h6D;
    #1;
    check("R9 divert obsOut follows", obsOut, 8'h6D);
    check("R3 divert baseOut idle", baseOut, 8'h00);

    // R5/R6: layer removal takes effect without an edge
    layerPresent = 1'b0;
    #1;
    check("R5 absent immediate baseOut", baseOut, 8'h6D);
    check("R6 absent immediate obsOut", obsOut, 8'h00);
    baseIn = 8'h24;
    #1;
    check("R9 absent baseOut follows", baseOut, 8'h24);
    layerPresent = 1'b1;
    #1;
    check("R3 divert restored obsOut", obsOut, 8'h24);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule